// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block sits beside a small CPU core and decides, once per decision cycle, whether the core should take an interrupt and which one. Five request lines feed it: vertical blank, LCD status, timer overflow, serial and keypad. A one-cycle strobe on a line latches a pending flag for that source. A 5-bit enable register masks the sources. A master enable flag gates every dispatch. The CPU sets the master enable only through an explicit strobe.

When the master enable is set and some enabled source is pending, the block takes the lowest-numbered one and emits a single-cycle take pulse with the source index and the fixed vector address. In the same cycle it raises a push request that carries the program counter the core presented during the decision cycle. It also issues a one-hot acknowledge. The pending flag of the serviced source is cleared, the master enable drops, and the controller stays in service for a fixed number of cycles before it makes another decision.

A halt request parks the controller in a halted state. Any enabled pending request releases it, whether or not the master enable is set.

The controller is a three-state machine:
- States: `ST_RUN` (decide), `ST_HALT` (core halted) and `ST_SVC` (service in progress).
- Transitions:
  - dispatch: `ST_RUN` to `ST_SVC`.
  - sleep: `ST_RUN` to `ST_HALT`, taken when `halt_req` is high and no enabled request is pending.
  - wake: `ST_HALT` to `ST_RUN`, taken with the master enable clear.
  - wake-dispatch: `ST_HALT` to `ST_SVC`, taken with the master enable set.
  - done: `ST_SVC` to `ST_RUN`, taken when the service timer expires.

Top module: `irq_dispatch`

## Requirements
- R1: No dispatch happens unless the master enable is set and at least one source is both pending and enabled; with the enable register zero, nothing is ever taken.
- R2: Source bit mapping is fixed: bit 0 vertical blank, bit 1 LCD status, bit 2 timer, bit 3 serial, bit 4 keypad. A `req_set` bit sets the matching `pend_o` bit on the next edge. A write with `en_wr` loads `en_o` from `en_wdata`.
- R3: Among enabled pending sources the lowest bit index wins, and `idx_o` gives that index.
- R4: `vec_o` is 0x40 + 8 × index, which gives 0x40, 0x48, 0x50, 0x58 and 0x60 for bits 0 to 4.
- R5: A dispatch clears the master enable on the same edge that raises `take_o`. `ime_set` sets it on the next edge, unless a dispatch happens on that edge, in which case the clear wins. Reset clears it.
- R6: `busy_o` is high for exactly 24 consecutive cycles, starting in the `take_o` cycle. No dispatch starts while it is high, even if the master enable is set again.
- R7: `halt_req` with no enabled pending source moves the controller to the halted state (`halted_o` = 1). A pending source that is not enabled does not release it. An enabled pending source releases it on the edge after its flag is set, with no dispatch if the master enable is clear.
- R8: `take_o` lasts one cycle and only one source is dispatched per decision. Other pending sources stay pending and are dispatched in later decisions.
- R9: In the `take_o` cycle, `ack_o` is one-hot at the serviced index. That source's pending flag reads 0 unless it was requested again on the same edge. All other pending flags are unchanged.
- R10: `push_req_o` is high together with `take_o`. `push_pc_o` holds the `pc_in` value from the decision cycle.
- R11: After reset the controller is running, not halted, not busy, and the pending, enable and master-enable flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | 5 | Per-source request strobes |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 5 | Enable register write data |
| ime_set | input | 1 | Master enable set strobe |
| halt_req | input | 1 | Core requests halt |
| pc_in | input | 16 | Current program counter |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| vec_o | output | 16 | Vector address of the serviced source |
| idx_o | output | 3 | Index of the serviced source |
| ack_o | output | 5 | One-hot acknowledge to sources |
| push_req_o | output | 1 | Stack push request |
| push_pc_o | output | 16 | Program counter to push |
| ime_o | output | 1 | Master enable flag |
| en_o | output | 5 | Enable register |
| pend_o | output | 5 | Pending flags |
| halted_o | output | 1 | Core is halted |
| busy_o | output | 1 | Service in progress |

## Verification
The assertions check on every cycle the properties that any single dispatch must have:
- the previous master enable was set and is now clear;
- the taken source was pending and enabled, and no lower enabled source was pending;
- the acknowledge is one-hot and the pulse is single;
- the serviced flag is cleared;
- each service window lasts 24 cycles;
- halt exits when an enabled request is pending.

Only the bench scenarios can show the value relationships that need a known history. These are the exact vector and index for each mix of requests and enables, the pushed program counter, the absence of a dispatch while the master enable is clear, deferred dispatch of the remaining sources after service, and staying halted on a request that is not enabled.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_SVC  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irq_src_regs.sv
// Pending flags and enable mask for the interrupt sources.
module irq_src_regs #(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_set,
    input  logic [N_SRC-1:0] clr_mask,
    input  logic             en_wr,
    input  logic [N_SRC-1:0] en_wdata,
    output logic [N_SRC-1:0] pend_q,
    output logic [N_SRC-1:0] en_q
);
    // A new request on the same edge as its clear keeps the flag set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | req_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Fixed priority selector: the lowest set bit wins.
module irq_prio_sel #(
    parameter int N_SRC = 5,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0] req,
    output logic [N_SRC-1:0] gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [N_SRC:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chain
        assign gnt[g]    = req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    assign any = seen[N_SRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (gnt[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_svc_timer.sv
// Counts the service window; done is high in the window's last cycle.
module irq_svc_timer #(
    parameter int SVC_CYC = 24,
    parameter int CNT_W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SVC_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
    parameter int          N_SRC    = 5,
    parameter int          PC_W     = 16,
    parameter logic [15:0] VEC_BASE = 16'h0040,
    parameter int          VEC_STEP = 8,
    parameter int          SVC_CYC  = 24,
    parameter int          IDX_W    = $clog2(N_SRC > 1 ? N_SRC : 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_set,
    input  logic             en_wr,
    input  logic [N_SRC-1:0] en_wdata,
    input  logic             ime_set,
    input  logic             halt_req,
    input  logic [PC_W-1:0]  pc_in,
    output logic             take_o,
    output logic [PC_W-1:0]  vec_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N_SRC-1:0] ack_o,
    output logic             push_req_o,
    output logic [PC_W-1:0]  push_pc_o,
    output logic             ime_o,
    output logic [N_SRC-1:0] en_o,
    output logic [N_SRC-1:0] pend_o,
    output logic             halted_o,
    output logic             busy_o
);
    import irq_pkg::*;

    localparam int CNT_W = $clog2(SVC_CYC + 1);

    function automatic logic [PC_W-1:0] vec_of(input logic [IDX_W-1:0] i);
        return PC_W'(int'(VEC_BASE) + VEC_STEP * int'(i));
    endfunction

    irq_state_e state_q, state_d;

    logic [N_SRC-1:0] pend_q, en_q, cand, gnt, clr_mask;
    logic [IDX_W-1:0] sel_idx;
    logic             cand_any;
    logic             go;
    logic             tmr_done;
    logic             ime_q;

    logic             take_q;
    logic [PC_W-1:0]  vec_q, push_pc_q;
    logic [IDX_W-1:0] idx_q;
    logic [N_SRC-1:0] ack_q;

    irq_src_regs #(.N_SRC(N_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_set  (req_set),
        .clr_mask (clr_mask),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .pend_q   (pend_q),
        .en_q     (en_q)
    );

    assign cand = pend_q & en_q;

    irq_prio_sel #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_sel (
        .req (cand),
        .gnt (gnt),
        .idx (sel_idx),
        .any (cand_any)
    );

    irq_svc_timer #(.SVC_CYC(SVC_CYC), .CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .done  (tmr_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and dispatch decision
    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (ime_q && cand_any) begin
                    state_d = ST_SVC;
                    go      = 1'b1;
                end else if (halt_req && !cand_any) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (cand_any) begin
                    if (ime_q) begin
                        state_d = ST_SVC;
                        go      = 1'b1;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_SVC: begin
                if (tmr_done) begin
                    state_d = ST_RUN;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    assign clr_mask = go ? gnt : '0;

    // Master enable: the dispatch clear wins over the set strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ime_q <= 1'b0;
        end else if (go) begin
            ime_q <= 1'b0;
        end else if (ime_set) begin
            ime_q <= 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_q    <= 1'b0;
            vec_q     <= '0;
            idx_q     <= '0;
            ack_q     <= '0;
            push_pc_q <= '0;
        end else begin
            take_q <= go;
            ack_q  <= go ? gnt : '0;
            if (go) begin
                vec_q     <= vec_of(sel_idx);
                idx_q     <= sel_idx;
                push_pc_q <= pc_in;
            end
        end
    end

    assign take_o     = take_q;
    assign vec_o      = vec_q;
    assign idx_o      = idx_q;
    assign ack_o      = ack_q;
    assign push_req_o = take_q;
    assign push_pc_o  = push_pc_q;
    assign ime_o      = ime_q;
    assign en_o       = en_q;
    assign pend_o     = pend_q;
    assign halted_o   = (state_q == ST_HALT);
    assign busy_o     = (state_q == ST_SVC);
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
    parameter int N_SRC   = 5,
    parameter int SVC_CYC = 24,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] req_set,
    input logic             take_o,
    input logic [IDX_W-1:0] idx_o,
    input logic [N_SRC-1:0] ack_o,
    input logic             push_req_o,
    input logic             ime_o,
    input logic [N_SRC-1:0] en_o,
    input logic [N_SRC-1:0] pend_o,
    input logic             halted_o,
    input logic             busy_o
);
    logic [31:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else begin
            run_len <= busy_o ? run_len + 1 : '0;
        end
    end

    AST_TAKE_NEEDS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(ime_o) && !ime_o)); // R1
    AST_TAKE_FROM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(pend_o & en_o) != '0)); // R1
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (($past(pend_o & en_o) & ((N_SRC'(1) << idx_o) - N_SRC'(1))) == '0)); // R3
    AST_IME_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !ime_o); // R5
    AST_SVC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == SVC_CYC)); // R6
    AST_NO_TAKE_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !$past(busy_o)); // R6
    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && ((pend_o & en_o) != '0)) |=> !halted_o); // R7
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R8
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o)); // R9
    AST_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (ack_o == (N_SRC'(1) << idx_o))); // R9
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (pend_o[idx_o] == $past(req_set[idx_o]))); // R9
    AST_PUSH_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        push_req_o == take_o); // R10
endmodule

bind irq_dispatch irq_dispatch_chk #(
    .N_SRC   (N_SRC),
    .SVC_CYC (SVC_CYC),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_set    (req_set),
    .take_o     (take_o),
    .idx_o      (idx_o),
    .ack_o      (ack_o),
    .push_req_o (push_req_o),
    .ime_o      (ime_o),
    .en_o       (en_o),
    .pend_o     (pend_o),
    .halted_o   (halted_o),
    .busy_o     (busy_o)
);

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  req_set = '0;
    logic        en_wr = 1'b0;
    logic [4:0]  en_wdata = '0;
    logic        ime_set = 1'b0;
    logic        halt_req = 1'b0;
    logic [15:0] pc_in = '0;
    logic        take_o, push_req_o, ime_o, halted_o, busy_o;
    logic [15:0] vec_o, push_pc_o;
    logic [2:0]  idx_o;
    logic [4:0]  ack_o, en_o, pend_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .en_wr(en_wr),
        .en_wdata(en_wdata), .ime_set(ime_set), .halt_req(halt_req),
        .pc_in(pc_in), .take_o(take_o), .vec_o(vec_o), .idx_o(idx_o),
        .ack_o(ack_o), .push_req_o(push_req_o), .push_pc_o(push_pc_o),
        .ime_o(ime_o), .en_o(en_o), .pend_o(pend_o),
        .halted_o(halted_o), .busy_o(busy_o)
    );

    // {en[4:0], req[4:0], ime, exp_take, exp_idx[2:0]}
    localparam logic [14:0] VECS [12] = '{
        {5'b11111, 5'b00001, 1'b1, 1'b1, 3'd0},
        {5'b11111, 5'b11110, 1'b1, 1'b1, 3'd1},
        {5'b11111, 5'b11100, 1'b1, 1'b1, 3'd2},
        {5'b11111, 5'b11000, 1'b1, 1'b1, 3'd3},
        {5'b11111, 5'b10000, 1'b1, 1'b1, 3'd4},
        {5'b11111, 5'b11111, 1'b1, 1'b1, 3'd0},
        {5'b11100, 5'b00111, 1'b1, 1'b1, 3'd2},
        {5'b10000, 5'b01111, 1'b1, 1'b0, 3'd0},
        {5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0},
        {5'b11111, 5'b00101, 1'b0, 1'b0, 3'd0},
        {5'b01010, 5'b11010, 1'b1, 1'b1, 3'd1},
        {5'b11000, 5'b11000, 1'b1, 1'b1, 3'd3}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_set = '0; en_wr = 1'b0; en_wdata = '0; ime_set = 1'b0; halt_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R11 reset state
        do_reset();
        check("R11 ime", ime_o, 0);
        check("R11 pend", pend_o, 0);
        check("R11 en", en_o, 0);
        check("R11 take", take_o, 0);
        check("R11 halted", halted_o, 0);
        check("R11 busy", busy_o, 0);

        // Vector table: R1 R2 R3 R4 R5 R9 R10
        for (int k = 0; k < 12; k++) begin
            logic [4:0] v_en, v_req;
            logic       v_ime, v_take;
            logic [2:0] v_idx;
            {v_en, v_req, v_ime, v_take, v_idx} = VECS[k];
            do_reset();
            pc_in = 16'h1200 + 16'(k);
            en_wr = 1'b1; en_wdata = v_en; req_set = v_req; ime_set = v_ime;
            @(negedge clk);
            en_wr = 1'b0; req_set = '0; ime_set = 1'b0;
            @(negedge clk);
            check("R1 take", take_o, v_take);
            check("R2 en", en_o, v_en);
            if (v_take) begin
                check("R3 idx", idx_o, v_idx);
                check("R4 vec", vec_o, 32'h40 + 8 * v_idx);
                check("R5 ime cleared", ime_o, 0);
                check("R9 ack", ack_o, 5'b1 << v_idx);
                check("R9 pend", pend_o, v_req & ~(5'b1 << v_idx));
                check("R10 push_req", push_req_o, 1);
                check("R10 push_pc", push_pc_o, 16'h1200 + 16'(k));
            end else begin
                check("R2 pend", pend_o, v_req);
                check("R5 ime kept", ime_o, v_ime);
                check("R9 no ack", ack_o, 0);
            end
        end

        // R6 R8: service window, ime set mid-service, deferred second source
        begin
            int n;
            bit extra;
            n = 0; extra = 0;
            do_reset();
            en_wr = 1'b1; en_wdata = 5'b11111; req_set = 5'b00110; ime_set = 1'b1;
            @(negedge clk);
            en_wr = 1'b0; req_set = '0; ime_set = 1'b0;
            @(negedge clk);
            check("R8 first take", take_o, 1);
            check("R3 first idx", idx_o, 1);
            while (busy_o && n < 100) begin
                n++;
                if (take_o && n > 1) extra = 1;
                ime_set = (n == 5);
                @(negedge clk);
            end
            ime_set = 1'b0;
            check("R6 busy length", n, 24);
            check("R6 no take in service", extra, 0);
            check("R5 ime set by strobe", ime_o, 1);
            check("R8 second still pending", pend_o, 5'b00100);
            @(negedge clk);
            check("R8 deferred take", take_o, 1);
            check("R8 deferred idx", idx_o, 2);
            check("R4 deferred vec", vec_o, 16'h0050);
        end

        // R7: halt, stay on disabled source, wake without dispatch, then dispatch
        do_reset();
        en_wr = 1'b1; en_wdata = 5'b00001; halt_req = 1'b1;
        @(negedge clk);
        en_wr = 1'b0; halt_req = 1'b0;
        check("R7 halted", halted_o, 1);
        req_set = 5'b00010;
        @(negedge clk);
        req_set = '0;
        @(negedge clk);
        check("R7 disabled keeps halt", halted_o, 1);
        check("R2 pend bit1", pend_o, 5'b00010);
        req_set = 5'b00001;
        @(negedge clk);
        req_set = '0;
        @(negedge clk);
        check("R7 woke", halted_o, 0);
        check("R7 no take without ime", take_o, 0);
        ime_set = 1'b1;
        @(negedge clk);
        ime_set = 1'b0;
        @(negedge clk);
        check("R7 take after wake", take_o, 1);
        check("R7 idx after wake", idx_o, 0);
        check("R9 pend after wake", pend_o, 5'b00010);

        finish_run();
    end
endmodule